// File: doc/BRIEF.md
# Skew-Tolerant Transition Trit Receiver

This block is the receive half of a self-clocked, two-wire, transition-coded serial link. The far end signals each symbol by toggling one or both of its two output wires. The receiver resynchronises both wires to its own clock and notices when the pair differs from the last value it accepted. It then waits one more clock so that a late second wire still falls into the same symbol. Finally it decodes a trit as the XOR of the new pair with the accepted reference. A toggle of only wire 0 carries a data 0, a toggle of only wire 1 carries a data 1, and a toggle of both is an acknowledge that also closes a frame.

Data bits are corrected by a writable polarity bit, which covers swapped wires. They are packed into a byte-wide frame buffer in arrival order. Each acknowledge that follows at least one bit reports a finished frame together with its length. The buffer can be read one byte at a time, which suits a block RAM. Every decoded trit also produces a one-cycle strobe, so a separate reply controller can answer each symbol.

Top module: `trit_rx`

## Requirements
- R1: After synchronous reset, trit_stb, frame_done and overflow are low and frame_len is zero, and the accepted reference pair is 00.
- R2: A toggle on a single wire gives exactly one trit_stb, high for one cycle, with trit_val equal to the new pair XOR the previous accepted pair. The strobe is sampled high after the (SYNC_STAGES+2)-th rising edge following the input change, which is the 4th edge with default parameters.
- R3: When the second wire toggles one clock after the first, the two changes decode as a single trit of value 11 (ACK), not as two data trits.
- R4: A change on a wire that reverts within one clock yields no trit_stb, and the reference pair is left as it was.
- R5: trit_val 01 is a data bit of value 0 and trit_val 10 is a data bit of value 1. Each data bit is XORed with the polarity register before it is stored.
- R6: A trit 11 that arrives when N ≥ 1 data bits are pending pulses frame_done for one cycle, one cycle after its trit_stb, with frame_len = N. It also restarts the count from zero.
- R7: A trit 11 with no pending data bits gives no frame_done.
- R8: Data bit n of a frame is stored at byte n/8, bit position n mod 8. Any unused upper bits of a partial last byte read as 0. rd_data returns the byte at rd_addr one clock after rd_addr is presented.
- R9: A cycle with pol_we high loads pol_d into the polarity register. The new value applies to every data bit decoded afterwards.
- R10: Once MAX_BITS data bits are pending, further data bits are discarded and overflow goes high. overflow stays high until the next trit 11, which reports frame_len = MAX_BITS and clears overflow.
- R11: Every decoded trit, acknowledges included, gives a trit_stb, and trit_val is never 00 while trit_stb is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 2 | Asynchronous transition-coded wire pair |
| pol_we | input | 1 | Write strobe for the polarity register |
| pol_d | input | 1 | New polarity value |
| trit_stb | output | 1 | One-cycle pulse per decoded trit |
| trit_val | output | 2 | Decoded trit (01 data 0, 10 data 1, 11 ACK), before polarity |
| frame_done | output | 1 | One-cycle pulse when a frame closes |
| frame_len | output | LEN_W | Bit count of the frame just closed |
| overflow | output | 1 | Data bits were discarded in the current frame |
| rd_addr | input | ADDR_W | Byte address into the frame buffer |
| rd_data | output | 8 | Registered byte read from the frame buffer |

## Verification
The bench times the first strobe against the input edge. A receiver with a missing synchroniser stage or a missing settling cycle would strobe one edge early, and with skewed wires it would report two data trits where there was one ACK. A one-clock glitch checks that a change which reverts produces no strobe; a design that latched the first sample would emit a phantom bit. An 11-bit frame, a frame decoded with inverted polarity and a run past 4096 bits check the byte and bit placement, the partial-byte flush on ACK, and the saturating count with its overflow flag. Back-to-back ACKs with nothing pending must strobe but never report an empty frame.

// File: rtl/trit_rx_pkg.sv
package trit_rx_pkg;
  typedef enum logic [1:0] {
    TRIT_NONE = 2'b00,
    TRIT_ZERO = 2'b01,
    TRIT_ONE  = 2'b10,
    TRIT_ACK  = 2'b11
  } trit_e;

  typedef enum logic {
    DET_IDLE   = 1'b0,
    DET_SETTLE = 1'b1
  } det_state_e;
endpackage

// File: rtl/trit_sync.sv
module trit_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[l]};
    end
    assign q[l] = chain[STAGES-1];
  end
endmodule

// File: rtl/trit_detect.sv
module trit_detect
  import trit_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pair,
  output logic       stb,
  output logic [1:0] trit
);
  det_state_e state;
  logic [1:0] ref_q;
  logic [1:0] diff;

  assign diff = pair ^ ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DET_IDLE;
      ref_q <= 2'b00;
      stb   <= 1'b0;
      trit  <= TRIT_NONE;
    end else begin
      stb <= 1'b0;
      case (state)
        DET_IDLE: begin
          if (diff != 2'b00) state <= DET_SETTLE;
        end
        default: begin
          // settling cycle over: both wires are read together
          state <= DET_IDLE;
          ref_q <= pair;
          if (diff != 2'b00) begin
            stb  <= 1'b1;
            trit <= diff;
          end
        end
      endcase
    end
  end

  a_r11_stb_nonzero: assert property (@(posedge clk) disable iff (rst)
    stb |-> (trit != TRIT_NONE));
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);
  a_r4_stb_after_settle: assert property (@(posedge clk) disable iff (rst)
    $rose(stb) |-> $past(state == DET_SETTLE));
endmodule

// File: rtl/trit_deframe.sv
module trit_deframe
  import trit_rx_pkg::*;
#(
  parameter int MAX_BITS = 4096,
  parameter int LEN_W    = $clog2(MAX_BITS + 1),
  parameter int ADDR_W   = $clog2((MAX_BITS + 7) / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [1:0]        trit,
  input  logic              pol,
  output logic              frame_done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              overflow,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = (MAX_BITS + 7) / 8;

  logic [7:0]        mem [DEPTH];
  logic [LEN_W-1:0]  cnt;
  logic [7:0]        acc;
  logic              is_ack, is_dat, room, bit_v;
  logic [7:0]        acc_ins;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_byte;

  always_comb begin
    is_ack  = stb && (trit == TRIT_ACK);
    is_dat  = stb && ((trit == TRIT_ZERO) || (trit == TRIT_ONE));
    room    = (cnt < LEN_W'(MAX_BITS));
    bit_v   = (trit == TRIT_ONE) ^ pol;
    acc_ins = acc | (8'(bit_v) << cnt[2:0]);
    wr_addr = ADDR_W'(cnt >> 3);
    wr_en   = 1'b0;
    wr_byte = acc_ins;
    if (is_dat && room && (cnt[2:0] == 3'd7)) wr_en = 1'b1;
    if (is_ack && (cnt[2:0] != 3'd0)) begin
      wr_en   = 1'b1;
      wr_byte = acc;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_byte;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      acc        <= '0;
      overflow   <= 1'b0;
      frame_done <= 1'b0;
      frame_len  <= '0;
    end else begin
      frame_done <= 1'b0;
      if (is_ack) begin
        if (cnt != '0) begin
          frame_done <= 1'b1;
          frame_len  <= cnt;
        end
        cnt      <= '0;
        acc      <= '0;
        overflow <= 1'b0;
      end else if (is_dat) begin
        if (room) begin
          cnt <= cnt + 1'b1;
          acc <= (cnt[2:0] == 3'd7) ? 8'h00 : acc_ins;
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end

  a_r6_done_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (frame_len != '0));
  a_r6_done_follows_ack: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(is_ack));
  a_r10_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= LEN_W'(MAX_BITS));
  a_r10_ovf_clears_on_ack: assert property (@(posedge clk) disable iff (rst)
    is_ack |=> !overflow);
endmodule

// File: rtl/trit_rx.sv
module trit_rx
  import trit_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BITS    = 4096,
  parameter int LEN_W       = $clog2(MAX_BITS + 1),
  parameter int ADDR_W      = $clog2((MAX_BITS + 7) / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        line_in,
  input  logic              pol_we,
  input  logic              pol_d,
  output logic              trit_stb,
  output logic [1:0]        trit_val,
  output logic              frame_done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              overflow,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [1:0] pair_s;
  logic       pol_q;

  trit_sync #(.LANES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(pair_s)
  );

  trit_detect u_det (
    .clk(clk), .rst(rst), .pair(pair_s), .stb(trit_stb), .trit(trit_val)
  );

  always_ff @(posedge clk) begin
    if (rst)         pol_q <= 1'b0;
    else if (pol_we) pol_q <= pol_d;
  end

  trit_deframe #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_dfr (
    .clk(clk), .rst(rst), .stb(trit_stb), .trit(trit_val), .pol(pol_q),
    .frame_done(frame_done), .frame_len(frame_len), .overflow(overflow),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  a_r9_pol_load: assert property (@(posedge clk) disable iff (rst)
    pol_we |=> (pol_q == $past(pol_d)));
  a_r1_no_done_without_stb: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(trit_stb));
endmodule

// File: tb/tb_trit_rx.sv
module tb_trit_rx;
  localparam int MAXB = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  line_in = 2'b00;
  logic        pol_we = 1'b0;
  logic        pol_d = 1'b0;
  logic        trit_stb;
  logic [1:0]  trit_val;
  logic        frame_done;
  logic [12:0] frame_len;
  logic        overflow;
  logic [8:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  int checks = 0, failures = 0;
  int stb_cnt = 0, done_cnt = 0;
  logic [1:0]  last_trit = 2'b00;
  logic [12:0] last_len = '0;

  always #5 clk = ~clk;

  trit_rx dut (
    .clk(clk), .rst(rst), .line_in(line_in), .pol_we(pol_we), .pol_d(pol_d),
    .trit_stb(trit_stb), .trit_val(trit_val), .frame_done(frame_done),
    .frame_len(frame_len), .overflow(overflow), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (!rst && trit_stb)   begin stb_cnt++;  last_trit = trit_val; end
    if (!rst && frame_done) begin done_cnt++; last_len = frame_len; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic send(input logic [1:0] t);
    @(negedge clk) line_in = line_in ^ t;
    repeat (7) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    send(b ? 2'b10 : 2'b01);
  endtask

  task automatic read_byte(input int a, output logic [7:0] v);
    @(negedge clk) rd_addr = 9'(a);
    @(negedge clk) v = rd_data;
  endtask

  task automatic t_reset();
    chk(trit_stb == 1'b0, "R1 trit_stb", int'(trit_stb), 0);
    chk(frame_done == 1'b0, "R1 frame_done", int'(frame_done), 0);
    chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
    chk(frame_len == '0, "R1 frame_len", int'(frame_len), 0);
  endtask

  task automatic t_latency();
    int first = 0;
    int s0 = stb_cnt;
    @(negedge clk) line_in[0] = ~line_in[0];
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (trit_stb && first == 0) first = k;
    end
    chk(first == 4, "R2 strobe edge", first, 4);
    chk(last_trit == 2'b01, "R2 trit value", int'(last_trit), 1);
    chk(stb_cnt - s0 == 1, "R2 strobe count", stb_cnt - s0, 1);
    send(2'b11);
    chk(last_len == 13'd1, "R6 one-bit frame", int'(last_len), 1);
  endtask

  task automatic t_skew();
    int s0 = stb_cnt, d0 = done_cnt;
    @(negedge clk) line_in[0] = ~line_in[0];
    @(negedge clk) line_in[1] = ~line_in[1];
    repeat (7) @(negedge clk);
    chk(stb_cnt - s0 == 1, "R3 one trit under skew", stb_cnt - s0, 1);
    chk(last_trit == 2'b11, "R3 skewed pair is ACK", int'(last_trit), 3);
    chk(done_cnt == d0, "R7 empty ACK no frame", done_cnt - d0, 0);
  endtask

  task automatic t_glitch();
    int s0 = stb_cnt;
    @(negedge clk) line_in[1] = ~line_in[1];
    @(negedge clk) line_in[1] = ~line_in[1];
    repeat (7) @(negedge clk);
    chk(stb_cnt == s0, "R4 reverted change no trit", stb_cnt - s0, 0);
    send(2'b01);
    chk(last_trit == 2'b01, "R4 reference kept", int'(last_trit), 1);
    send(2'b11);
  endtask

  task automatic t_frame();
    logic [10:0] pat = 11'b101_1100_1011;
    logic [7:0] v;
    int d0 = done_cnt;
    for (int i = 0; i < 11; i++) send_bit(pat[i]);
    send(2'b11);
    chk(done_cnt - d0 == 1, "R6 frame_done once", done_cnt - d0, 1);
    chk(last_len == 13'd11, "R6 frame_len", int'(last_len), 11);
    read_byte(0, v);
    chk(v == pat[7:0], "R5 R8 byte0", int'(v), int'(pat[7:0]));
    read_byte(1, v);
    chk(v == {5'b0, pat[10:8]}, "R8 partial byte1", int'(v), int'(pat[10:8]));
  endtask

  task automatic t_polarity();
    logic [7:0] v;
    @(negedge clk) begin pol_we = 1'b1; pol_d = 1'b1; end
    @(negedge clk) pol_we = 1'b0;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    send(2'b11);
    chk(last_len == 13'd3, "R9 length", int'(last_len), 3);
    read_byte(0, v);
    chk(v == 8'b0000_0110, "R9 inverted bits", int'(v), 6);
    @(negedge clk) begin pol_we = 1'b1; pol_d = 1'b0; end
    @(negedge clk) pol_we = 1'b0;
  endtask

  task automatic t_empty_acks();
    int s0 = stb_cnt, d0 = done_cnt;
    send(2'b11); send(2'b11);
    chk(stb_cnt - s0 == 2, "R11 ACKs strobe", stb_cnt - s0, 2);
    chk(done_cnt == d0, "R7 no empty frame", done_cnt - d0, 0);
  endtask

  task automatic t_overflow();
    logic [7:0] v, e;
    for (int i = 0; i < MAXB + 4; i++) begin
      send_bit((i % 3) == 0);
      if (i == MAXB - 1) chk(overflow == 1'b0, "R10 no overflow at limit", int'(overflow), 0);
    end
    chk(overflow == 1'b1, "R10 overflow set", int'(overflow), 1);
    send(2'b11);
    chk(last_len == 13'(MAXB), "R10 saturated length", int'(last_len), MAXB);
    chk(overflow == 1'b0, "R10 overflow cleared", int'(overflow), 0);
    e = '0;
    for (int j = 0; j < 8; j++) e[j] = (((MAXB - 8 + j) % 3) == 0);
    read_byte(MAXB / 8 - 1, v);
    chk(v == e, "R10 R8 last byte kept", int'(v), int'(e));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_skew();
    t_glitch();
    t_frame();
    t_polarity();
    t_empty_acks();
    t_overflow();
    summary();
  end
endmodule